// File: doc/BRIEF.md
# Pulse-Handshake Fall-Through FIFO

This block is a small first-in first-out buffer, 16 words of 4 bits, that is written and read with level control pulses and reports its state with two ready flags. A producer raises the shift-in control while the input-ready flag is high. The word on the data input is then captured, and the flag drops to show the stage is busy. Lowering shift-in commits the word into storage. Committed words move towards the output end without any request, so the oldest word appears on the data output with the output-ready flag set.

A consumer raises shift-out to take the presented word. The output-ready flag drops while the pulse is high. When shift-out falls, the next stored word is presented. When the buffer runs dry, the last word removed stays on the output. Two sequences are also supported. Shift-in may be held high on a full buffer and is then served as soon as a slot frees. Shift-out may be held high on an empty buffer and then takes the next arriving word by itself.

The model is fully clocked. Every control is sampled on the rising edge of `clk`, and a word advances at most one stage per clock. The input side runs a three-state controller: `IN_READY`, `IN_CAPTURED` and `IN_BLOCKED`. Its transitions are:
- `IN_READY` to `IN_CAPTURED` on shift-in high.
- `IN_CAPTURED` to `IN_READY` on shift-in low with space left.
- `IN_CAPTURED` to `IN_BLOCKED` on shift-in low with the buffer full.
- `IN_BLOCKED` to `IN_READY` once the occupancy drops below 16.

The output side runs `OUT_EMPTY`, `OUT_VALID` and `OUT_BUSY`. Its transitions are:
- `OUT_EMPTY` to `OUT_VALID` when storage holds a word.
- `OUT_VALID` to `OUT_BUSY` on shift-out high.
- `OUT_BUSY` to `OUT_EMPTY` on shift-out low.

Top module: `ff_pulse_fifo`

## Requirements
- R1: While `mrst` is high, and after it falls, `in_rdy` is 1, `out_rdy` is 0, `dout` is 0 and all stored words are discarded. No discarded word ever reaches the output.
- R2: If `shin` is high at a rising edge while `in_rdy` is high, `din` is captured, and `in_rdy` is 0 after that edge.
- R3: The first edge with `shin` low after a capture commits the word. `in_rdy` then returns to 1 if fewer than 16 words are held, and stays 0 if 16 are held. The occupancy never exceeds 16.
- R4: A shift-in pulse while 16 words are held has no effect: no word is added and the stored words and their order are unchanged.
- R5: If `shin` is held high on a full buffer, `in_rdy` rises after a removal frees a slot. The word on `din` is then captured, and it is committed when `shin` falls.
- R6: Committed words reach `dout` with `out_rdy` set, in the order they were written.
- R7: A rising edge that sees `shout` high while `out_rdy` is high removes the presented word. `out_rdy` is 0 after that edge, and `dout` does not change while the word is presented or being removed.
- R8: After `shout` falls, the next stored word is presented with `out_rdy` high. If none is left, `out_rdy` stays 0 and `dout` keeps the last removed word.
- R9: If `shout` is held high on an empty buffer, the next word written is presented with `out_rdy` high for exactly one cycle and is removed automatically. No further word is removed until `shout` has gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| mrst | input | 1 | Master reset, active high, synchronous |
| din | input | 4 | Word to be written |
| shin | input | 1 | Shift-in control pulse |
| shout | input | 1 | Shift-out control pulse |
| in_rdy | output | 1 | Input stage empty and able to capture a word |
| out_rdy | output | 1 | A valid word is presented on `dout` |
| dout | output | 4 | Presented word, or the last word removed |

## Verification
The occupancy and capture properties rely on the producer issuing shift-in pulses only through the input-ready handshake. A pulse given on a full buffer is harmless here, because the input controller ignores it while blocked, so the overflow property holds for any stimulus. The bench drives every control on the falling clock edge and keeps each pulse at least one clock high and one clock low, so every transition is seen by the sampling edge. It sweeps every fill level from 1 to 16 words with arithmetic data patterns. It also drives the full-buffer pulse, the held shift-in, the held shift-out and the mid-stream reset cases on purpose.

// File: rtl/ff_pulse_fifo_pkg.sv
package ff_pulse_fifo_pkg;

    typedef enum logic [1:0] {
        IN_READY    = 2'd0,
        IN_CAPTURED = 2'd1,
        IN_BLOCKED  = 2'd2
    } in_state_e;

    typedef enum logic [1:0] {
        OUT_EMPTY = 2'd0,
        OUT_VALID = 2'd1,
        OUT_BUSY  = 2'd2
    } out_state_e;

endpackage

// File: rtl/ff_word_store.sv
module ff_word_store #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_word,
    input  logic          pop,
    output logic [W-1:0]  head_word,
    output logic [CW-1:0] cnt
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_word;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_word = mem[rd_ptr];

endmodule

// File: rtl/ff_in_ctl.sv
module ff_in_ctl
    import ff_pulse_fifo_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shin,
    input  logic [W-1:0] din,
    input  logic         space_now,
    input  logic         space_next,
    output logic         in_rdy,
    output logic         commit,
    output logic [W-1:0] held_word
);

    in_state_e state, state_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= IN_READY;
            held_word <= '0;
        end else begin
            state <= state_n;
            if (state == IN_READY && shin) held_word <= din;
        end
    end

    always_comb begin
        state_n = state;
        in_rdy  = 1'b0;
        commit  = 1'b0;
        unique case (state)
            IN_READY: begin
                in_rdy = 1'b1;
                if (shin) state_n = IN_CAPTURED;
            end
            IN_CAPTURED: begin
                if (!shin) begin
                    commit  = 1'b1;
                    state_n = space_next ? IN_READY : IN_BLOCKED;
                end
            end
            IN_BLOCKED: begin
                if (space_now) state_n = IN_READY;
            end
            default: state_n = IN_READY;
        endcase
    end

endmodule

// File: rtl/ff_out_ctl.sv
module ff_out_ctl
    import ff_pulse_fifo_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shout,
    input  logic         word_avail,
    input  logic [W-1:0] head_word,
    output logic         pop,
    output logic         remove,
    output logic         out_rdy,
    output logic [W-1:0] dout
);

    out_state_e state, state_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OUT_EMPTY;
            dout  <= '0;
        end else begin
            state <= state_n;
            if (pop) dout <= head_word;
        end
    end

    always_comb begin
        state_n = state;
        pop     = 1'b0;
        remove  = 1'b0;
        out_rdy = 1'b0;
        unique case (state)
            OUT_EMPTY: begin
                if (word_avail) begin
                    pop     = 1'b1;
                    state_n = OUT_VALID;
                end
            end
            OUT_VALID: begin
                out_rdy = 1'b1;
                if (shout) begin
                    remove  = 1'b1;
                    state_n = OUT_BUSY;
                end
            end
            OUT_BUSY: begin
                if (!shout) state_n = OUT_EMPTY;
            end
            default: state_n = OUT_EMPTY;
        endcase
    end

endmodule

// File: rtl/ff_pulse_fifo.sv
module ff_pulse_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         mrst,
    input  logic [W-1:0] din,
    input  logic         shin,
    input  logic         shout,
    output logic         in_rdy,
    output logic         out_rdy,
    output logic [W-1:0] dout
);

    logic          commit, remove, pop;
    logic [W-1:0]  held_word, head_word;
    logic [CW-1:0] store_cnt;
    logic [CW-1:0] occ, occ_n;

    // occupancy counts every word between commit and removal
    always_comb begin
        occ_n = occ;
        if (commit && !remove)      occ_n = occ + CW'(1);
        else if (remove && !commit) occ_n = occ - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (mrst) occ <= '0;
        else      occ <= occ_n;
    end

    ff_in_ctl #(.W(W)) u_in (
        .clk        (clk),
        .rst        (mrst),
        .shin       (shin),
        .din        (din),
        .space_now  (occ < CW'(DEPTH)),
        .space_next (occ_n < CW'(DEPTH)),
        .in_rdy     (in_rdy),
        .commit     (commit),
        .held_word  (held_word)
    );

    ff_word_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (mrst),
        .push      (commit),
        .push_word (held_word),
        .pop       (pop),
        .head_word (head_word),
        .cnt       (store_cnt)
    );

    ff_out_ctl #(.W(W)) u_out (
        .clk        (clk),
        .rst        (mrst),
        .shout      (shout),
        .word_avail (store_cnt != '0),
        .head_word  (head_word),
        .pop        (pop),
        .remove     (remove),
        .out_rdy    (out_rdy),
        .dout       (dout)
    );

endmodule

// File: rtl/ff_pulse_fifo_chk.sv
module ff_pulse_fifo_chk #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          mrst,
    input logic          shin,
    input logic          shout,
    input logic          in_rdy,
    input logic          out_rdy,
    input logic [W-1:0]  dout,
    input logic [CW-1:0] occ
);

    p_reset_state_r1: assert property (@(posedge clk)
        mrst |=> (in_rdy && !out_rdy && dout == '0 && occ == '0));

    p_capture_busy_r2: assert property (@(posedge clk) disable iff (mrst)
        (in_rdy && shin) |=> !in_rdy);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (mrst)
        occ <= CW'(DEPTH));

    p_full_no_ready_r3: assert property (@(posedge clk) disable iff (mrst)
        (occ == CW'(DEPTH)) |-> !in_rdy);

    p_full_ignored_r4: assert property (@(posedge clk) disable iff (mrst)
        (occ == CW'(DEPTH) && !out_rdy) |=> (occ == CW'(DEPTH)));

    p_remove_busy_r7: assert property (@(posedge clk) disable iff (mrst)
        (out_rdy && shout) |=> (!out_rdy && $stable(dout)));

    p_hold_word_r7: assert property (@(posedge clk) disable iff (mrst)
        (out_rdy && !shout) |=> (out_rdy && $stable(dout)));

    p_latched_r8: assert property (@(posedge clk) disable iff (mrst)
        !out_rdy |=> (out_rdy || $stable(dout)));

endmodule

bind ff_pulse_fifo ff_pulse_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .mrst    (mrst),
    .shin    (shin),
    .shout   (shout),
    .in_rdy  (in_rdy),
    .out_rdy (out_rdy),
    .dout    (dout),
    .occ     (occ)
);

// File: tb/ff_pulse_fifo_test.sv
module ff_pulse_fifo_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int DEPTH      = 16;

    logic         clk = 1'b0;
    logic         mrst = 1'b1;
    logic [W-1:0] din = '0;
    logic         shin = 1'b0;
    logic         shout = 1'b0;
    logic         in_rdy, out_rdy;
    logic [W-1:0] dout;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ff_pulse_fifo #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .mrst(mrst), .din(din), .shin(shin), .shout(shout),
        .in_rdy(in_rdy), .out_rdy(out_rdy), .dout(dout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int k, input int s);
        return W'((k * 7 + s * 3 + 1) % 16);
    endfunction

    // write one word; n_after = words held once committed
    task automatic push(input logic [W-1:0] w, input int n_after);
        @(negedge clk);
        shin = 1'b1; din = w;
        @(negedge clk);
        chk(in_rdy == 1'b0, "R2 busy after capture", int'(in_rdy), 0);
        shin = 1'b0;
        @(negedge clk);
        chk(in_rdy == (n_after < DEPTH), "R3 ready after commit",
            int'(in_rdy), int'(n_after < DEPTH));
    endtask

    task automatic pop(input logic [W-1:0] exp);
        int t = 0;
        while (!out_rdy && t < 50) begin @(negedge clk); t++; end
        chk(out_rdy == 1'b1, "R6 word presented", int'(out_rdy), 1);
        chk(dout == exp, "R6 order", int'(dout), int'(exp));
        shout = 1'b1;
        @(negedge clk);
        chk(out_rdy == 1'b0 && dout == exp, "R7 busy and held",
            int'(dout), int'(exp));
        shout = 1'b0;
        @(negedge clk);
    endtask

    task automatic reset_pulse();
        @(negedge clk); mrst = 1'b1;
        @(negedge clk);
        @(negedge clk); mrst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] last;
        int hi;
        repeat (3) @(negedge clk);
        chk(in_rdy && !out_rdy && dout == '0, "R1 reset state", int'(dout), 0);
        mrst = 1'b0;
        @(negedge clk);
        chk(in_rdy && !out_rdy, "R1 after release", int'(out_rdy), 0);

        // R6/R8 sweep over every fill level
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) push(pat(k, n), k + 1);
            for (int k = 0; k < n; k++) pop(pat(k, n));
            repeat (4) @(negedge clk);
            last = pat(n - 1, n);
            chk(!out_rdy && dout == last, "R8 latched when empty", int'(dout), int'(last));
            chk(in_rdy == 1'b1, "R3 ready when empty", int'(in_rdy), 1);
        end

        // R4: pulse on a full buffer is ignored
        for (int k = 0; k < DEPTH; k++) push(pat(k, 20), k + 1);
        @(negedge clk); shin = 1'b1; din = 4'hF;
        @(negedge clk); @(negedge clk);
        chk(in_rdy == 1'b0, "R4 no ready when full", int'(in_rdy), 0);
        shin = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_rdy == 1'b0, "R4 still full", int'(in_rdy), 0);
        for (int k = 0; k < DEPTH; k++) pop(pat(k, 20));
        repeat (6) @(negedge clk);
        chk(!out_rdy, "R4 no extra word", int'(out_rdy), 0);

        // R5: shin held on a full buffer
        for (int k = 0; k < DEPTH; k++) push(pat(k, 30), k + 1);
        @(negedge clk); shin = 1'b1; din = 4'hA;
        pop(pat(0, 30));
        repeat (4) @(negedge clk);
        chk(in_rdy == 1'b0, "R5 captured pending word", int'(in_rdy), 0);
        shin = 1'b0;
        @(negedge clk);
        chk(in_rdy == 1'b0, "R5 full again after commit", int'(in_rdy), 0);
        for (int k = 1; k < DEPTH; k++) pop(pat(k, 30));
        pop(4'hA);

        // R9: shout held on an empty buffer
        @(negedge clk); shout = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_rdy, "R9 nothing while empty", int'(out_rdy), 0);
        @(negedge clk); shin = 1'b1; din = 4'h6;
        @(negedge clk); shin = 1'b0;
        hi = 0;
        for (int c = 0; c < 8; c++) begin @(negedge clk); if (out_rdy) hi++; end
        chk(hi == 1, "R9 one-cycle ready pulse", hi, 1);
        chk(dout == 4'h6 && in_rdy, "R9 word removed", int'(dout), 6);
        push(4'h9, 1);
        repeat (6) @(negedge clk);
        chk(!out_rdy && dout == 4'h6, "R9 waits for shout low", int'(dout), 6);
        shout = 1'b0;
        pop(4'h9);

        // R1: reset mid-stream discards words
        push(4'h3, 1); push(4'h4, 2); push(4'h5, 3);
        reset_pulse();
        chk(in_rdy && !out_rdy && dout == '0, "R1 mid-stream reset", int'(dout), 0);
        repeat (6) @(negedge clk);
        chk(!out_rdy, "R1 storage cleared", int'(out_rdy), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule